// File: doc/BRIEF.md
# Configurable UART transmit serializer

This block turns parallel characters into an asynchronous serial bit stream. A character is offered on a ready/valid input; once taken, the block sends a low start bit, then the data bits least significant first, then an optional parity bit, and ends with one or two high stop bits. Bit timing comes from an external one-cycle enable, `bit_tick`, that pulses once per bit period. The serializer holds each bit on the line from one tick to the next.

The frame format is chosen per character by three encoded fields: a character-length code, a parity code and a stop-bit code. All three are captured together with the data at the moment the character is taken, so they may change freely while a frame is on the line. The parity code covers even, odd, a forced 0, a forced 1, and no parity bit at all. Control inputs enable or disable the transmitter, with disable taking priority. Two further inputs begin and end a break, where the line is held low; ending the break takes priority. A pulsed soft reset abandons a frame in flight. A `busy` output marks the frame on the line and a one-cycle `done` pulse marks its end.

Top module: `ser_tx_core`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at high level. Each bit stays on `line_out` for exactly one `bit_tick` interval, and the line is high when no frame is being sent.
- R2: Length code `len_sel` 0 sends DATA_W bits, 2 sends DATA_W-1, 3 sends DATA_W-2, and 1 is treated as 0. The upper data bits that are not sent have no effect on parity.
- R3: Parity code `par_sel` 0 gives even parity over the sent bits, 1 odd, 2 a forced 0, 3 a forced 1; any value 4 to 7 sends no parity bit. The parity bit follows the last data bit.
- R4: Stop code `stp_sel` 2 sends two stop bits; every other value sends one.
- R5: Data and all three format codes are captured in the cycle the character is taken. Later changes to them have no effect on that frame.
- R6: `in_ready` is high only when the serializer is idle, the transmitter is enabled, no break is active and `tx_rst` is low. A character offered while a frame is in progress is not taken.
- R7: `tx_en` enables and `tx_dis` disables the transmitter. Both are pulses whose effect persists. Disable wins when both are high. The transmitter is disabled after reset.
- R8: A `brk_start` pulse holds `line_out` low from the next cycle until a `brk_stop` pulse, which returns the line high from the next cycle. When both are high in the same cycle, the break ends.
- R9: A `tx_rst` pulse returns the serializer to idle in the next cycle: `busy` low, line high, and no `done` for the abandoned frame.
- R10: `busy` is high from the first cycle of the start bit through the last cycle of the final stop bit. `done` is high for exactly one cycle, the cycle after the final stop bit, with `busy` low.
- R11: After the asynchronous reset, `line_out` is high and `busy`, `done` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character, bit 0 sent first |
| in_ready | output | 1 | Character taken when high with `in_valid` |
| len_sel | input | 2 | Character-length code |
| par_sel | input | 3 | Parity code |
| stp_sel | input | 2 | Stop-bit code |
| tx_en | input | 1 | Enable pulse |
| tx_dis | input | 1 | Disable pulse, dominant |
| brk_start | input | 1 | Begin break pulse |
| brk_stop | input | 1 | End break pulse, dominant |
| tx_rst | input | 1 | Soft reset pulse of the serializer |
| line_out | output | 1 | Serial line |
| busy | output | 1 | Frame on the line |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default DATA_W of 8 and drives `bit_tick` once every four clocks. With DATA_W at 8, all three length codes (8, 7 and 6 bits) are reachable, with enough unsent upper bits to show that they are left out of parity. The short tick period keeps each frame near fifty cycles, so every parity and stop combination fits in one run. It also makes it cheap to confirm, cycle by cycle, that the line only changes right after a tick.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } ser_state_e;

  localparam logic [1:0] LEN_MINUS1 = 2'd2;
  localparam logic [1:0] LEN_MINUS2 = 2'd3;

  localparam logic [2:0] PAR_EVEN  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_ZERO  = 3'd2;
  localparam logic [2:0] PAR_ONE   = 3'd3;

  localparam logic [1:0] STOP_TWO  = 2'd2;

endpackage

// File: rtl/ser_tx_rstsync.sv
module ser_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ser_tx_fmt.sv
module ser_tx_fmt
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        len_sel,
  input  logic [2:0]        par_sel,
  input  logic [1:0]        stp_sel,
  output logic [DATA_W-1:0] data_m,
  output logic [CNT_W-1:0]  last_idx,
  output logic              par_on,
  output logic              par_bit,
  output logic              two_stop
);
  localparam logic [CNT_W-1:0] IDX_FULL = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] IDX_M1   = CNT_W'(DATA_W - 2);
  localparam logic [CNT_W-1:0] IDX_M2   = CNT_W'(DATA_W - 3);

  logic ones_odd;

  always_comb begin
    case (len_sel)
      LEN_MINUS1: last_idx = IDX_M1;
      LEN_MINUS2: last_idx = IDX_M2;
      default:    last_idx = IDX_FULL;
    endcase
  end

  // unsent upper bits are cleared so they take no part in parity
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign data_m[g] = in_data[g] & (CNT_W'(g) <= last_idx);
  end

  assign ones_odd = ^data_m;

  always_comb begin
    par_on  = 1'b1;
    par_bit = 1'b0;
    case (par_sel)
      PAR_EVEN: par_bit = ones_odd;
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_ZERO: par_bit = 1'b0;
      PAR_ONE:  par_bit = 1'b1;
      default:  par_on  = 1'b0;
    endcase
  end

  assign two_stop = (stp_sel == STOP_TWO);
endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_dis,
  input  logic brk_start,
  input  logic brk_stop,
  output logic en_q,
  output logic brk_q
);
  logic en_d;
  logic brk_d;

  always_comb begin
    en_d = en_q;
    if (tx_dis) begin
      en_d = 1'b0;
    end else if (tx_en) begin
      en_d = 1'b1;
    end
  end

  always_comb begin
    brk_d = brk_q;
    if (brk_stop) begin
      brk_d = 1'b0;
    end else if (brk_start) begin
      brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      brk_q <= brk_d;
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CNT_W-1:0]  ld_last,
  input  logic              ld_par_on,
  input  logic              ld_par_bit,
  input  logic              ld_two,
  output logic              ser_line,
  output logic              busy,
  output logic              idle,
  output logic              done
);
  ser_state_e        state_q,  state_d;
  logic [DATA_W-1:0] shreg_q,  shreg_d;
  logic [CNT_W-1:0]  idx_q,    idx_d;
  logic [CNT_W-1:0]  last_q,   last_d;
  logic              par_on_q, par_on_d;
  logic              par_q,    par_d;
  logic              two_q,    two_d;
  logic              more_q,   more_d;
  logic              done_q,   done_d;

  always_comb begin
    state_d  = state_q;
    shreg_d  = shreg_q;
    idx_d    = idx_q;
    last_d   = last_q;
    par_on_d = par_on_q;
    par_d    = par_q;
    two_d    = two_q;
    more_d   = more_q;
    done_d   = 1'b0;
    if (clr) begin
      state_d = ST_IDLE;
      more_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load) begin
            state_d  = ST_WAIT;
            shreg_d  = ld_data;
            last_d   = ld_last;
            par_on_d = ld_par_on;
            par_d    = ld_par_bit;
            two_d    = ld_two;
          end
        end
        ST_WAIT: begin
          // align the start bit to a bit boundary
          if (bit_tick) state_d = ST_START;
        end
        ST_START: begin
          if (bit_tick) begin
            state_d = ST_DATA;
            idx_d   = '0;
          end
        end
        ST_DATA: begin
          if (bit_tick) begin
            shreg_d = shreg_q >> 1;
            if (idx_q == last_q) begin
              if (par_on_q) begin
                state_d = ST_PAR;
              end else begin
                state_d = ST_STOP;
                more_d  = two_q;
              end
            end else begin
              idx_d = idx_q + CNT_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (bit_tick) begin
            state_d = ST_STOP;
            more_d  = two_q;
          end
        end
        ST_STOP: begin
          if (bit_tick) begin
            if (more_q) begin
              more_d = 1'b0;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      par_on_q <= 1'b0;
      par_q    <= 1'b0;
      two_q    <= 1'b0;
      more_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      shreg_q  <= shreg_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      par_on_q <= par_on_d;
      par_q    <= par_d;
      two_q    <= two_d;
      more_q   <= more_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: ser_line = 1'b0;
      ST_DATA:  ser_line = shreg_q[0];
      ST_PAR:   ser_line = par_q;
      default:  ser_line = 1'b1;
    endcase
  end

  assign busy = (state_q == ST_START) || (state_q == ST_DATA) ||
                (state_q == ST_PAR)   || (state_q == ST_STOP);
  assign idle = (state_q == ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        len_sel,
  input  logic [2:0]        par_sel,
  input  logic [1:0]        stp_sel,
  input  logic              tx_en,
  input  logic              tx_dis,
  input  logic              brk_start,
  input  logic              brk_stop,
  input  logic              tx_rst,
  output logic              line_out,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              rst_sync_n;
  logic              en_q;
  logic              brk_q;
  logic              ser_line;
  logic              idle;
  logic              load;
  logic [DATA_W-1:0] data_m;
  logic [CNT_W-1:0]  last_idx;
  logic              par_on;
  logic              par_bit;
  logic              two_stop;

  ser_tx_rstsync #(.STAGES(2)) u_rs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ser_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tx_en     (tx_en),
    .tx_dis    (tx_dis),
    .brk_start (brk_start),
    .brk_stop  (brk_stop),
    .en_q      (en_q),
    .brk_q     (brk_q)
  );

  ser_tx_fmt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fmt (
    .in_data  (in_data),
    .len_sel  (len_sel),
    .par_sel  (par_sel),
    .stp_sel  (stp_sel),
    .data_m   (data_m),
    .last_idx (last_idx),
    .par_on   (par_on),
    .par_bit  (par_bit),
    .two_stop (two_stop)
  );

  assign in_ready = idle & en_q & ~brk_q & ~tx_rst;
  assign load     = in_valid & in_ready;

  ser_tx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bit_tick   (bit_tick),
    .clr        (tx_rst),
    .load       (load),
    .ld_data    (data_m),
    .ld_last    (last_idx),
    .ld_par_on  (par_on),
    .ld_par_bit (par_bit),
    .ld_two     (two_stop),
    .ser_line   (ser_line),
    .busy       (busy),
    .idle       (idle),
    .done       (done)
  );

  assign line_out = ser_line & ~brk_q;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst_ok,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic line_out,
  input logic brk_start,
  input logic brk_stop,
  input logic tx_dis,
  input logic tx_rst
);
  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    in_ready |-> !busy);

  assert_dis_wins_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    tx_dis |=> !in_ready);

  assert_brk_low_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (brk_start && !brk_stop) |=> (!line_out && !in_ready));

  assert_rst_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    tx_rst |=> (!busy && !done));

  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);
endmodule

bind ser_tx_core ser_tx_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .in_ready  (in_ready),
  .busy      (busy),
  .done      (done),
  .line_out  (line_out),
  .brk_start (brk_start),
  .brk_stop  (brk_stop),
  .tx_dis    (tx_dis),
  .tx_rst    (tx_rst)
);

// File: tb/sim_ser_tx_core.sv
module sim_ser_tx_core;
  localparam int DW   = 8;
  localparam int TDIV = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_tick;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic [1:0]    len_sel;
  logic [2:0]    par_sel;
  logic [1:0]    stp_sel;
  logic          tx_en, tx_dis, brk_start, brk_stop, tx_rst;
  logic          line_out, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int tcnt  = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  end
  assign bit_tick = (tcnt == TDIV - 1);

  ser_tx_core #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .len_sel(len_sel), .par_sel(par_sel), .stp_sel(stp_sel),
    .tx_en(tx_en), .tx_dis(tx_dis), .brk_start(brk_start), .brk_stop(brk_stop),
    .tx_rst(tx_rst), .line_out(line_out), .busy(busy), .done(done)
  );

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // send one character and rebuild its frame from the line at each tick
  task automatic run_frame(input logic [7:0] d, input logic [1:0] l,
                           input logic [2:0] p, input logic [1:0] s,
                           input bit scramble, input bit offer, input string req);
    logic [15:0] eb, cb;
    int en, cn, nb;
    logic ones;
    bit got_done, stab_bad, rdy_bad, prev_busy, prev_tick, prev_line;
    eb = '0; cb = '0; cn = 0; ones = 1'b0;
    nb = (l == 2'd2) ? 7 : (l == 2'd3) ? 6 : 8;
    eb[0] = 1'b0; en = 1;
    for (int i = 0; i < nb; i++) begin
      eb[en] = d[i]; en++; ones ^= d[i];
    end
    if (p < 3'd4) begin
      eb[en] = (p == 3'd0) ? ones : (p == 3'd1) ? ~ones : (p == 3'd2) ? 1'b0 : 1'b1;
      en++;
    end
    eb[en] = 1'b1; en++;
    if (s == 2'd2) begin eb[en] = 1'b1; en++; end

    @(negedge clk);
    len_sel = l; par_sel = p; stp_sel = s; in_data = d; in_valid = 1'b1;
    chk_eq("R6", "ready when idle", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    if (offer) in_data = ~d; else in_valid = 1'b0;
    if (scramble) begin
      len_sel = (l == 2'd0) ? 2'd3 : 2'd0;
      par_sel = p ^ 3'd1;
      stp_sel = (s == 2'd2) ? 2'd0 : 2'd2;
    end
    got_done = 0; stab_bad = 0; rdy_bad = 0;
    prev_busy = 0; prev_tick = 0; prev_line = 1;
    for (int k = 0; k < 400 && !got_done; k++) begin
      if (busy && prev_busy && !prev_tick && line_out != prev_line) stab_bad = 1;
      if (busy && in_ready) rdy_bad = 1;
      if (busy && bit_tick && cn < 16) begin cb[cn] = line_out; cn++; end
      if (done) begin
        got_done = 1;
        in_valid = 1'b0;
        chk_eq("R10", "busy low with done", {31'd0, busy}, 32'd0);
        chk_eq("R1", "idle line after frame", {31'd0, line_out}, 32'd1);
      end
      prev_busy = busy; prev_tick = bit_tick; prev_line = line_out;
      if (!got_done) @(negedge clk);
    end
    in_valid = 1'b0;
    chk_eq("R10", "done seen", {31'd0, got_done}, 32'd1);
    chk_eq("R1", "bit stays one tick", {31'd0, stab_bad}, 32'd0);
    chk_eq(req, "frame length", cn, en);
    chk_eq(req, "frame bits", {16'd0, cb & ((16'd1 << en) - 16'd1)}, {16'd0, eb});
    if (offer) chk_eq("R6", "no ready while busy", {31'd0, rdy_bad}, 32'd0);
    @(negedge clk);
    chk_eq("R10", "done one cycle", {31'd0, done}, 32'd0);
    if (offer) begin
      repeat (3 * TDIV) @(negedge clk);
      chk_eq("R6", "offer during frame not taken", {31'd0, busy}, 32'd0);
    end
  endtask

  task automatic t_reset();
    chk_eq("R11", "line after reset", {31'd0, line_out}, 32'd1);
    chk_eq("R11", "busy after reset", {31'd0, busy}, 32'd0);
    chk_eq("R11", "done after reset", {31'd0, done}, 32'd0);
    chk_eq("R11", "ready after reset", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic t_enable();
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); tx_en = 1'b0;
    chk_eq("R7", "ready after enable", {31'd0, in_ready}, 32'd1);
    repeat (5) @(negedge clk);
    chk_eq("R7", "enable persists", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_disable();
    bit moved;
    moved = 0;
    @(negedge clk); tx_en = 1'b1; tx_dis = 1'b1;
    @(negedge clk); tx_en = 1'b0; tx_dis = 1'b0;
    chk_eq("R7", "disable wins", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_data = 8'h55;
    for (int k = 0; k < 4 * TDIV; k++) begin
      @(negedge clk);
      if (busy || !line_out) moved = 1;
    end
    in_valid = 1'b0;
    chk_eq("R7", "disabled ignores offer", {31'd0, moved}, 32'd0);
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); tx_en = 1'b0;
    chk_eq("R7", "re-enabled", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_break();
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    chk_eq("R8", "break low", {31'd0, line_out}, 32'd0);
    chk_eq("R8", "no ready in break", {31'd0, in_ready}, 32'd0);
    repeat (6) @(negedge clk);
    chk_eq("R8", "break held", {31'd0, line_out}, 32'd0);
    brk_start = 1'b1; brk_stop = 1'b1;
    @(negedge clk); brk_start = 1'b0; brk_stop = 1'b0;
    chk_eq("R8", "stop wins", {31'd0, line_out}, 32'd1);
    brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    chk_eq("R8", "break again", {31'd0, line_out}, 32'd0);
    brk_stop = 1'b1;
    @(negedge clk); brk_stop = 1'b0;
    chk_eq("R8", "break ends", {31'd0, line_out}, 32'd1);
    chk_eq("R8", "ready after break", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_txrst();
    bit stray;
    stray = 0;
    @(negedge clk);
    len_sel = 2'd0; par_sel = 3'd4; stp_sel = 2'd0; in_data = 8'h00; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
    repeat (2 * TDIV + 1) @(negedge clk);
    chk_eq("R9", "frame running", {31'd0, busy}, 32'd1);
    tx_rst = 1'b1;
    @(negedge clk); tx_rst = 1'b0;
    chk_eq("R9", "busy cleared", {31'd0, busy}, 32'd0);
    chk_eq("R9", "line high", {31'd0, line_out}, 32'd1);
    for (int k = 0; k < 20 * TDIV; k++) begin
      @(negedge clk);
      if (done || busy) stray = 1;
    end
    chk_eq("R9", "no done after abandon", {31'd0, stray}, 32'd0);
    chk_eq("R9", "ready after reset pulse", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    len_sel = '0; par_sel = '0; stp_sel = '0;
    tx_en = 1'b0; tx_dis = 1'b0; brk_start = 1'b0; brk_stop = 1'b0; tx_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    run_frame(8'hA5, 2'd0, 3'd4, 2'd0, 0, 0, "R1");
    run_frame(8'hD3, 2'd2, 3'd0, 2'd0, 0, 0, "R2");
    run_frame(8'h81, 2'd1, 3'd4, 2'd0, 0, 0, "R2");
    run_frame(8'hED, 2'd3, 3'd1, 2'd2, 0, 0, "R4");
    run_frame(8'hFF, 2'd0, 3'd2, 2'd0, 0, 0, "R3");
    run_frame(8'h00, 2'd0, 3'd3, 2'd0, 0, 0, "R3");
    run_frame(8'h3C, 2'd0, 3'd7, 2'd2, 0, 0, "R3");
    run_frame(8'h96, 2'd2, 3'd1, 2'd2, 1, 0, "R5");
    run_frame(8'h5A, 2'd0, 3'd0, 2'd0, 0, 1, "R6");
    t_break();
    t_disable();
    t_txrst();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule